// File: doc/BRIEF.md
# Sequential Integer Divider with Trap-Free Corner Cases

This block divides one integer operand by another over several clock cycles and returns the quotient. The operands are 64 bits wide by default. A single mode input chooses whether both operands are treated as unsigned or as two's-complement signed values. The caller raises `start` for one cycle while the block is idle. The block copies the operands into its own registers and raises `busy`. When the quotient is ready it pulses `done` for one cycle. The quotient stays on the output until the next operation finishes.

The block never signals an error. A zero divisor gives a quotient of zero in both modes. In signed mode, the most negative value divided by minus one has no representable quotient, so the block returns the dividend unchanged. Both of these cases finish after a short fixed delay, without running the iteration.

Every other division runs a radix-2 restoring iteration on operand magnitudes, one quotient bit per cycle. A final cycle negates the quotient when the operand signs differ. This makes signed division truncate toward zero.

Top module: `qdiv_unit`

## Requirements
- R1: When `start` is high at a rising edge while `busy` is low, the block captures `dividend`, `divisor` and `signed_mode`, and `busy` is high in the following cycle.
- R2: With `signed_mode` = 0 and a non-zero divisor, `quotient` equals floor(dividend / divisor), with both operands read as unsigned.
- R3: With `signed_mode` = 1 and a non-zero divisor (excluding the R5 case), `quotient` equals the two's-complement quotient truncated toward zero. The operands are read as two's complement, with bit WIDTH-1 as the sign.
- R4: A zero divisor gives a `quotient` of zero in both modes. `done` rises 2 cycles after the accepting edge.
- R5: With `signed_mode` = 1, a dividend of 1 followed by WIDTH-1 zeros and a divisor of all ones give a `quotient` equal to the dividend. `done` rises 2 cycles after the accepting edge.
- R6: Any other division raises `done` WIDTH+2 cycles after the accepting edge, and `busy` stays high for exactly those WIDTH+2 cycles.
- R7: A `start` pulse while `busy` is high is ignored. The running operation keeps its operands and its timing, and no further operation follows.
- R8: `done` is high for exactly one cycle per operation. `quotient` changes only in a cycle where `done` is high, and otherwise holds its value.
- R9: A `start` in the same cycle that `done` is high is accepted, so operations can run back to back with no idle cycle between them.
- R10: While reset (`rst_n` low) is applied, `busy` and `done` are low and `quotient` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a division (accepted only when idle) |
| dividend | input | WIDTH | Numerator operand |
| divisor | input | WIDTH | Denominator operand |
| signed_mode | input | 1 | 1 = two's-complement operands, 0 = unsigned |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| quotient | output | WIDTH | Registered quotient of the last completed operation |

## Verification
Two events can fall in the same cycle: completion of one division (the `done` pulse and the update of `quotient`) and acceptance of the next `start`.

The exhaustive sweep over a 6-bit instance provokes this on every operation after the first. Each new `start` is driven in the very cycle where the previous `done` is observed. The bench judges the overlap in three ways:
- the quotient sampled in that cycle must be the old operation's result;
- `busy` must be high one cycle later;
- the new operation must then finish with its own result and latency.

A separate sequence provokes the opposite overlap, a `start` that arrives while an operation is running. The bench confirms that the running operation keeps its operands and timing and that no second operation starts.

// File: rtl/qdiv_pkg.sv
package qdiv_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_ITER  = 2'd2,
    ST_FIX   = 2'd3
  } qdiv_state_e;
endpackage

// File: rtl/qdiv_prep.sv
module qdiv_prep #(
  parameter int WIDTH = 64
) (
  input  logic [WIDTH-1:0] num_i,
  input  logic [WIDTH-1:0] den_i,
  input  logic             sgn_i,
  output logic [WIDTH-1:0] mag_num_o,
  output logic [WIDTH-1:0] mag_den_o,
  output logic             negate_o,
  output logic             zero_den_o,
  output logic             ovf_o
);
  localparam logic [WIDTH-1:0] MOST_NEG = {1'b1, {(WIDTH-1){1'b0}}};
  localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

  // Absolute value when the operand is read as signed, identity otherwise.
  function automatic logic [WIDTH-1:0] magnitude(input logic [WIDTH-1:0] v,
                                                 input logic s);
    return (s && v[WIDTH-1]) ? (~v + 1'b1) : v;
  endfunction

  assign mag_num_o  = magnitude(num_i, sgn_i);
  assign mag_den_o  = magnitude(den_i, sgn_i);
  assign negate_o   = sgn_i & (num_i[WIDTH-1] ^ den_i[WIDTH-1]);
  assign zero_den_o = (den_i == '0);
  assign ovf_o      = sgn_i && (num_i == MOST_NEG) && (den_i == ALL_ONES);
endmodule

// File: rtl/qdiv_core.sv
module qdiv_core #(
  parameter int WIDTH = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic             step_en,
  input  logic [WIDTH-1:0] mag_num_i,
  input  logic [WIDTH-1:0] mag_den_i,
  output logic [WIDTH-1:0] quo_o
);
  logic [WIDTH-1:0] rem_q, quo_q, den_q;
  logic [2*WIDTH-1:0] nxt;

  // One restoring step: shift in the next dividend bit, subtract when it fits.
  function automatic logic [2*WIDTH-1:0] rs_step(input logic [WIDTH-1:0] r,
                                                 input logic [WIDTH-1:0] q,
                                                 input logic [WIDTH-1:0] d);
    logic [WIDTH:0] sh, diff;
    sh   = {r, q[WIDTH-1]};
    diff = sh - {1'b0, d};
    if (!diff[WIDTH]) return {diff[WIDTH-1:0], q[WIDTH-2:0], 1'b1};
    return {sh[WIDTH-1:0], q[WIDTH-2:0], 1'b0};
  endfunction

  assign nxt = rs_step(rem_q, quo_q, den_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem_q <= '0;
      quo_q <= '0;
      den_q <= '0;
    end else if (load_en) begin
      rem_q <= '0;
      quo_q <= mag_num_i;
      den_q <= mag_den_i;
    end else if (step_en) begin
      rem_q <= nxt[2*WIDTH-1:WIDTH];
      quo_q <= nxt[WIDTH-1:0];
    end
  end

  assign quo_o = quo_q;

  // R2: partial remainder never reaches the divisor while iterating
  rem_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_en |-> (rem_q < den_q));
endmodule

// File: rtl/qdiv_ctrl.sv
module qdiv_ctrl
  import qdiv_pkg::*;
#(
  parameter int WIDTH = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic special_i,
  output logic accept_o,
  output logic load_o,
  output logic step_o,
  output logic fix_o,
  output logic busy_o,
  output logic done_o
);
  localparam int CW = $clog2(WIDTH);
  localparam int LW = $clog2(WIDTH + 3);

  qdiv_state_e state_q;
  logic [CW-1:0] cnt_q;
  logic done_q;

  assign accept_o = start_i && (state_q == ST_IDLE);
  assign load_o   = (state_q == ST_SETUP);
  assign step_o   = (state_q == ST_ITER);
  assign fix_o    = (state_q == ST_FIX);
  assign busy_o   = (state_q != ST_IDLE);
  assign done_o   = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= (state_q == ST_FIX);
      case (state_q)
        ST_IDLE:  if (start_i) state_q <= ST_SETUP;
        ST_SETUP: begin
          cnt_q   <= '0;
          state_q <= special_i ? ST_FIX : ST_ITER;
        end
        ST_ITER: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == CW'(WIDTH - 1)) state_q <= ST_FIX;
        end
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  // Checker-side latency counter: busy cycles of the current operation.
  logic [LW-1:0] lat_q;
  always_ff @(posedge clk) begin
    if (!rst_n)        lat_q <= '0;
    else if (accept_o) lat_q <= '0;
    else if (busy_o)   lat_q <= lat_q + 1'b1;
  end

  // R4 R5 R6
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (lat_q == LW'(WIDTH + 2) || lat_q == LW'(2)));

  // R4 R5
  short_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_o && special_i) |=> fix_o);

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R1
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept_o |=> busy_o);
endmodule

// File: rtl/qdiv_unit.sv
module qdiv_unit #(
  parameter int WIDTH = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [WIDTH-1:0] dividend,
  input  logic [WIDTH-1:0] divisor,
  input  logic             signed_mode,
  output logic             busy,
  output logic             done,
  output logic [WIDTH-1:0] quotient
);
  localparam logic [WIDTH-1:0] MOST_NEG = {1'b1, {(WIDTH-1){1'b0}}};
  localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

  logic [WIDTH-1:0] opa_q, opb_q, quot_q;
  logic             sgn_q;
  logic [WIDTH-1:0] mag_num, mag_den, core_quo;
  logic             negate, zero_den, ovf_case, special;
  logic             accept, load_en, step_en, fix_en, busy_w, done_w;

  // Final quotient selection: defined values first, then sign fix-up.
  function automatic logic [WIDTH-1:0] finish_quo(input logic [WIDTH-1:0] q,
                                                  input logic neg,
                                                  input logic zd,
                                                  input logic ov);
    if (zd) return '0;
    if (ov) return MOST_NEG;
    return neg ? (~q + 1'b1) : q;
  endfunction

  qdiv_prep #(.WIDTH(WIDTH)) u_prep (
    .num_i      (opa_q),
    .den_i      (opb_q),
    .sgn_i      (sgn_q),
    .mag_num_o  (mag_num),
    .mag_den_o  (mag_den),
    .negate_o   (negate),
    .zero_den_o (zero_den),
    .ovf_o      (ovf_case)
  );

  assign special = zero_den | ovf_case;

  qdiv_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start),
    .special_i (special),
    .accept_o  (accept),
    .load_o    (load_en),
    .step_o    (step_en),
    .fix_o     (fix_en),
    .busy_o    (busy_w),
    .done_o    (done_w)
  );

  qdiv_core #(.WIDTH(WIDTH)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_en   (load_en),
    .step_en   (step_en),
    .mag_num_i (mag_num),
    .mag_den_i (mag_den),
    .quo_o     (core_quo)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      opa_q  <= '0;
      opb_q  <= '0;
      sgn_q  <= 1'b0;
      quot_q <= '0;
    end else begin
      if (accept) begin
        opa_q <= dividend;
        opb_q <= divisor;
        sgn_q <= signed_mode;
      end
      if (fix_en) quot_q <= finish_quo(core_quo, negate, zero_den, ovf_case);
    end
  end

  assign busy     = busy_w;
  assign done     = done_w;
  assign quotient = quot_q;

  // R7
  ignore_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_w && start) |=> ($stable(opa_q) && $stable(opb_q) && $stable(sgn_q)));

  // R8
  hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done_w |-> $stable(quot_q));

  // R4
  zero_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_w && opb_q == '0) |-> (quot_q == '0));

  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_w && sgn_q && opa_q == MOST_NEG && opb_q == ALL_ONES) |-> (quot_q == MOST_NEG));

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_w |-> !busy_w);
endmodule

// File: tb/qdiv_unit_test.sv
module qdiv_unit_test;
  localparam int SW = 6;
  localparam int WW = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic          s_start = 1'b0, s_sg = 1'b0;
  logic [SW-1:0] s_a = '0, s_b = '0;
  logic          s_busy, s_done;
  logic [SW-1:0] s_q;

  logic          w_start = 1'b0, w_sg = 1'b0;
  logic [WW-1:0] w_a = '0, w_b = '0;
  logic          w_busy, w_done;
  logic [WW-1:0] w_q;

  qdiv_unit #(.WIDTH(SW)) uut (
    .clk(clk), .rst_n(rst_n), .start(s_start), .dividend(s_a), .divisor(s_b),
    .signed_mode(s_sg), .busy(s_busy), .done(s_done), .quotient(s_q));

  qdiv_unit #(.WIDTH(WW)) uut_wide (
    .clk(clk), .rst_n(rst_n), .start(w_start), .dividend(w_a), .divisor(w_b),
    .signed_mode(w_sg), .busy(w_busy), .done(w_done), .quotient(w_q));

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=<190000", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  function automatic logic [SW-1:0] exp_small(input logic [SW-1:0] a,
                                              input logic [SW-1:0] b, input logic s);
    int sa, sb;
    if (b == 0) return '0;
    if (!s) return a / b;
    sa = $signed(a);
    sb = $signed(b);
    if (sa == -(1 << (SW - 1)) && sb == -1) return a;
    return SW'(sa / sb);
  endfunction

  function automatic logic [WW-1:0] exp_wide(input logic [WW-1:0] a,
                                             input logic [WW-1:0] b, input logic s);
    longint sa, sb;
    if (b == 0) return '0;
    if (!s) return a / b;
    sa = $signed(a);
    sb = $signed(b);
    if (a == {1'b1, {(WW-1){1'b0}}} && sb == -1) return a;
    return WW'(sa / sb);
  endfunction

  function automatic string tag_of(input bit zd, input bit ov, input logic s);
    if (zd) return "R4";
    if (ov) return "R5";
    return s ? "R3" : "R2";
  endfunction

  // Called at a negedge; returns at the negedge where done is seen.
  task automatic run_small(input logic [SW-1:0] a, input logic [SW-1:0] b,
                           input logic s, input string acc_tag);
    int n;
    bit zd, ov;
    logic [SW-1:0] e;
    zd = (b == 0);
    ov = s && (a == {1'b1, {(SW-1){1'b0}}}) && (b == '1);
    e  = exp_small(a, b, s);
    s_a = a; s_b = b; s_sg = s; s_start = 1'b1;
    @(posedge clk); @(negedge clk);
    s_start = 1'b0;
    chk(s_busy == 1'b1, acc_tag, 64'(s_busy), 64'd1);
    n = 0;
    while (!s_done && n < 100) begin @(negedge clk); n++; end
    chk(n == ((zd || ov) ? 2 : SW + 2), (zd || ov) ? tag_of(zd, ov, s) : "R6",
        64'(n), 64'((zd || ov) ? 2 : SW + 2));
    chk(s_q == e, tag_of(zd, ov, s), 64'(s_q), 64'(e));
  endtask

  task automatic run_wide(input logic [WW-1:0] a, input logic [WW-1:0] b,
                          input logic s);
    int n;
    bit zd, ov;
    logic [WW-1:0] e;
    zd = (b == 0);
    ov = s && (a == {1'b1, {(WW-1){1'b0}}}) && (b == '1);
    e  = exp_wide(a, b, s);
    w_a = a; w_b = b; w_sg = s; w_start = 1'b1;
    @(posedge clk); @(negedge clk);
    w_start = 1'b0;
    n = 0;
    while (!w_done && n < 200) begin @(negedge clk); n++; end
    chk(n == ((zd || ov) ? 2 : WW + 2), (zd || ov) ? tag_of(zd, ov, s) : "R6",
        64'(n), 64'((zd || ov) ? 2 : WW + 2));
    chk(w_q == e, tag_of(zd, ov, s), w_q, e);
  endtask

  initial begin
    logic [SW-1:0] held;
    int n;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(s_busy == 0 && s_done == 0, "R10", {s_busy, s_done}, 0);
    chk(s_q == 0, "R10", 64'(s_q), 0);
    chk(w_busy == 0 && w_done == 0 && w_q == 0, "R10", w_q, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // Exhaustive sweep; every run after the first starts in the done cycle (R9)
    for (int m = 0; m < 2; m++)
      for (int a = 0; a < (1 << SW); a++)
        for (int b = 0; b < (1 << SW); b++)
          run_small(SW'(a), SW'(b), m[0], "R9");

    // R8: done lasts one cycle and the quotient holds with inputs changing
    held = s_q;
    s_a = 6'd7; s_b = 6'd1; s_sg = 1'b0;
    @(negedge clk);
    chk(s_done == 0, "R8", 64'(s_done), 0);
    repeat (5) @(negedge clk);
    chk(s_q == held, "R8", 64'(s_q), 64'(held));

    // R1: accept from an idle state
    run_small(6'd45, 6'd4, 1'b0, "R1");

    // R7: start during busy is ignored
    @(negedge clk);
    s_a = 6'd10; s_b = 6'd3; s_sg = 1'b0; s_start = 1'b1;
    @(posedge clk); @(negedge clk);
    s_start = 1'b0;
    n = 0;
    @(negedge clk); n++;
    @(negedge clk); n++;
    s_a = 6'd63; s_b = 6'd1; s_start = 1'b1;
    @(posedge clk); @(negedge clk); n++;
    s_start = 1'b0;
    while (!s_done && n < 100) begin @(negedge clk); n++; end
    chk(n == SW + 2, "R7", 64'(n), 64'(SW + 2));
    chk(s_q == 6'd3, "R7", 64'(s_q), 64'd3);
    repeat (SW + 4) @(negedge clk);
    chk(s_busy == 0 && s_q == 6'd3, "R7", {s_busy, 6'd0} | 64'(s_q), 64'd3);

    // Full-width corner cases
    run_wide(64'd100, 64'd7, 1'b0);
    run_wide(-64'sd100, 64'd7, 1'b1);
    run_wide(64'd100, -64'sd7, 1'b1);
    run_wide({1'b1, 63'd0}, '1, 1'b1);
    run_wide({1'b1, 63'd0}, '1, 1'b0);
    run_wide(64'h0123_4567_89ab_cdef, 64'd0, 1'b0);
    run_wide(-64'sd5, 64'd0, 1'b1);
    run_wide('1, 64'd1, 1'b0);
    run_wide('1, 64'd3, 1'b0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule